// File: doc/BRIEF.md
# Two-Master Target Bus Arbiter

This block decides which of two upstream masters may use one peripheral-side target bus. Requester A is the CPU-side main bus. Requester B is the shared main bus that carries every other master. Each requester raises a level request. The arbiter returns a one-hot grant and holds it until the target reports that the transfer has finished.

A 2-bit mode input picks the priority policy at run time. In fixed mode requester B always wins a tie. In toggled mode a requester whose request is accepted becomes the lower-priority side for the next decision. If that requester already held the lower priority, the order is left as it was. The arbiter decides only while the target is idle, so the grant never moves in the middle of a transfer. A multi-bus design places one copy per target bus, and every copy is independent.

Grant encoding: `grant[0]` is requester A and `grant[1]` is requester B. A decision made at a clock edge shows on `grant` right after that edge. After a completion, the grant drops for one cycle before the next decision.

Top module: `tgt_arb2`

## Requirements
- R1: After reset, `grant` is 2'b00 and the priority state favours requester B.
- R2: With `prio_mode` of 00, 10 or 11 (fixed mode), an idle arbiter that sees both requests grants B (`grant`=2'b10) in the next cycle.
- R3: With `prio_mode`=01 (toggled mode), an idle arbiter that sees both requests grants the current higher-priority requester in the next cycle. That requester then becomes the lower-priority one.
- R4: In toggled mode, a lone request from the current lower-priority requester is granted and leaves the priority order unchanged. A lone request from the higher-priority requester flips the order.
- R5: When the arbiter is idle and exactly one request is high, that request is granted in the next cycle, whatever the priority state.
- R6: A non-zero grant keeps its value until `tgt_done` is sampled high while the grant is active. The grant is then 2'b00 in the next cycle. Request and mode inputs have no effect while a grant is held.
- R7: A grant accepted in fixed mode leaves the priority state unchanged. A mode change takes effect only at the next decision.
- R8: `grant` never has both bits set. It stays 2'b00 when the arbiter is idle and no request is present. `tgt_done` is ignored while no grant is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_a | input | 1 | Request from the CPU-side main bus |
| req_b | input | 1 | Request from the shared main bus |
| prio_mode | input | 2 | 01 selects toggled priority; every other value selects fixed priority |
| tgt_done | input | 1 | Target signals completion of the granted transfer |
| grant | output | 2 | One-hot grant: bit 0 is A, bit 1 is B |

## Verification
The assertions assume that every input is a known 0 or 1 and is synchronous to `clk`. They also assume that `tgt_done` may arrive at any time, including while no grant is held. Requests are treated as levels that may fall before they are granted, so no property depends on a request being held. The stimulus drives every input only at the falling edge and only with 0 or 1. It pulses `tgt_done` at random, including in idle cycles, so the cases where the arbiter must ignore it are covered.

// File: rtl/arb2_pkg.sv
package arb2_pkg;
  localparam int MODE_W  = 2;
  localparam int N_REQ   = 2;
  localparam int IDX_A   = 0;
  localparam int IDX_B   = 1;
  localparam logic [MODE_W-1:0] MODE_TOGGLE = 2'b01;
  typedef logic [N_REQ-1:0] grant_t;
endpackage

// File: rtl/arb2_mode_dec.sv
module arb2_mode_dec
  import arb2_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output logic              toggle
);
  // Only the toggle code selects rotation; all other codes behave as fixed.
  always_comb toggle = (mode == MODE_TOGGLE);
endmodule

// File: rtl/arb2_pick.sv
module arb2_pick (
  input  logic req_a,
  input  logic req_b,
  input  logic hi_b,
  input  logic toggle,
  output logic win_a,
  output logic win_b
);
  logic b_first;
  always_comb begin
    b_first = toggle ? hi_b : 1'b1;
    win_b   = req_b & (~req_a | b_first);
    win_a   = req_a & (~req_b | ~b_first);
  end
endmodule

// File: rtl/arb2_prio_reg.sv
module arb2_prio_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic toggle,
  input  logic win_a,
  output logic hi_b
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      hi_b <= 1'b1;
    else if (accept && toggle)
      hi_b <= win_a;  // the accepted side becomes the lower priority
  end

  // R7
  fixed_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !toggle) |=> $stable(hi_b));
endmodule

// File: rtl/tgt_arb2.sv
module tgt_arb2
  import arb2_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_a,
  input  logic              req_b,
  input  logic [MODE_W-1:0] prio_mode,
  input  logic              tgt_done,
  output logic [N_REQ-1:0]  grant
);
  logic   toggle, hi_b, win_a, win_b, idle, accept;
  grant_t grant_q;

  arb2_mode_dec u_dec (.mode(prio_mode), .toggle(toggle));

  arb2_pick u_pick (
    .req_a(req_a), .req_b(req_b), .hi_b(hi_b), .toggle(toggle),
    .win_a(win_a), .win_b(win_b)
  );

  always_comb begin
    idle   = (grant_q == '0);
    accept = idle && (req_a || req_b);
  end

  arb2_prio_reg u_prio (
    .clk(clk), .rst_n(rst_n), .accept(accept), .toggle(toggle),
    .win_a(win_a), .hi_b(hi_b)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      grant_q <= '0;
    else if (!idle) begin
      if (tgt_done) grant_q <= '0;
    end else begin
      grant_q[IDX_A] <= win_a;
      grant_q[IDX_B] <= win_b;
    end
  end

  assign grant = grant_q;

  // R8
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R8
  no_req_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == 2'b00 && !req_a && !req_b) |=> grant == 2'b00);
  // R6
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != 2'b00 && !tgt_done) |=> $stable(grant));
  // R6
  grant_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != 2'b00 && tgt_done) |=> grant == 2'b00);
  // R2
  fixed_b_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == 2'b00 && req_a && req_b && prio_mode != 2'b01) |=> grant == 2'b10);
  // R5
  lone_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == 2'b00 && req_a && !req_b) |=> grant == 2'b01);
  // R5
  lone_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == 2'b00 && !req_a && req_b) |=> grant == 2'b10);
endmodule

// File: tb/sim_tgt_arb2.sv
module sim_tgt_arb2;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_a = 1'b0, req_b = 1'b0, tgt_done = 1'b0;
  logic [1:0] prio_mode = 2'b00;
  logic [1:0] grant;

  int checks = 0;
  int errors = 0;
  logic [1:0] eg = 2'b00;   // expected grant
  logic       ehi = 1'b1;   // expected: B holds higher priority
  string      tag = "R8";
  string      force_tag = "";
  bit         done_flag = 0;

  always #2.5 clk = ~clk;

  tgt_arb2 u0 (.clk(clk), .rst_n(rst_n), .req_a(req_a), .req_b(req_b),
               .prio_mode(prio_mode), .tgt_done(tgt_done), .grant(grant));

  task automatic check(string t, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: grant=%b expected %b at %0t", t, act, exp, $time);
    end
  endtask

  // Expected-value model from the requirements, advanced once per edge.
  task automatic model_step();
    logic tog, wb;
    tog = (prio_mode == 2'b01);
    if (eg != 2'b00) begin
      tag = "R6";
      if (tgt_done) eg = 2'b00;
    end else if (req_a && req_b) begin
      wb  = tog ? ehi : 1'b1;
      tag = tog ? "R3" : "R2";
      eg  = wb ? 2'b10 : 2'b01;
      if (tog) ehi = ~wb;
    end else if (req_a || req_b) begin
      tag = (tog && (req_b != ehi)) ? "R4" : "R5";
      eg  = req_b ? 2'b10 : 2'b01;
      if (tog) ehi = req_a;
    end else begin
      tag = "R8";
      eg  = 2'b00;
    end
  endtask

  task automatic cyc(logic a, logic b, logic [1:0] m, logic d);
    req_a = a; req_b = b; prio_mode = m; tgt_done = d;
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(force_tag != "" ? force_tag : tag, grant, eg);
    if (grant[0] && grant[1]) check("R8", grant, eg);
  endtask

  initial begin
    int seed_init;
    seed_init = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    check("R1", grant, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", grant, 2'b00);

    // R8: done while idle is ignored
    cyc(0, 0, 2'b00, 1);
    // R2: fixed tie, B wins; codes 10 and 11 also fixed
    cyc(1, 1, 2'b00, 0); cyc(1, 1, 2'b01, 1); cyc(0, 0, 2'b00, 0);
    cyc(1, 1, 2'b10, 0); cyc(0, 0, 2'b00, 1); cyc(0, 0, 2'b00, 0);
    cyc(1, 1, 2'b11, 0); cyc(0, 0, 2'b00, 1); cyc(0, 0, 2'b00, 0);
    // R3: toggled ties alternate B then A
    cyc(1, 1, 2'b01, 0); cyc(0, 0, 2'b01, 1); cyc(0, 0, 2'b01, 0);
    cyc(1, 1, 2'b01, 0); cyc(0, 0, 2'b01, 1); cyc(0, 0, 2'b01, 0);
    // R4: B now higher; lone A (lower) keeps order, so tie then goes to B
    cyc(1, 0, 2'b01, 0); cyc(0, 0, 2'b01, 1); cyc(0, 0, 2'b01, 0);
    cyc(1, 1, 2'b01, 0); cyc(0, 0, 2'b01, 1); cyc(0, 0, 2'b01, 0);
    // R7: A is higher now; fixed-mode lone A must not flip the order
    force_tag = "R7";
    cyc(1, 0, 2'b00, 0); cyc(0, 1, 2'b01, 0); cyc(1, 1, 2'b11, 1);
    cyc(0, 0, 2'b00, 0);
    cyc(1, 1, 2'b01, 0);   // expects A
    cyc(0, 0, 2'b01, 1); cyc(0, 0, 2'b01, 0);
    force_tag = "";

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] m;
      m = ($urandom % 4 == 0) ? 2'($urandom) : 2'b01;
      cyc(1'($urandom), 1'($urandom), m, ($urandom % 3) == 0);
    end

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule